// File: doc/BRIEF.md
# Protect Boundary Write-Authorization Controller

This block sits behind the serial front end of a small non-volatile word memory. It decides whether each decoded instruction may change anything. It holds three pieces of state: a write-enable latch, a protect boundary with a cleared marker, and a permanent lock flag. For each instruction it receives the two-bit opcode, the address field and the sampled levels of the protect-select and program-enable pins. The instruction arrives as a one-cycle `instr_valid_i` pulse. One cycle later the block answers with a grant pulse or a deny pulse. For a protect read it answers with a read-back word instead.

Changes to the protect boundary are guarded by an arming instruction. The arming instruction must be the instruction directly before the change. A cleared boundary and a boundary explicitly written to all ones hold the same value, but the block treats them differently. The lock flag can never be reset by any instruction. Serial shifting and the timing of non-volatile programming belong to neighbouring blocks.

Top module: `prot_auth_ctrl`

## Requirements
- R1: After reset the write-enable latch is clear and no write is granted. The enable instruction sets the latch: protect-select low, opcode 00, top two address bits 11. The disable instruction clears it: protect-select low, opcode 00, top two address bits 00.
- R2: Protect-select low sends an opcode to the memory array, and a memory read (opcode 10) gives no output pulse. Protect-select high sends the same opcode to the protect boundary. Opcode 10 then pulses `prot_rd_valid_o`, with `prot_rd_data_o` = {1'b0, boundary}. The read works whatever the arming and write-enable state.
- R3: The arming instruction (protect-select high, opcode 00, top two address bits 11) is accepted only when the write-enable latch is set and program-enable is high.
- R4: A protect clear, protect write or lock is granted only if an accepted arming instruction came immediately before it. Any other instruction in between cancels the arming.
- R5: A memory write (opcode 01, protect-select low) to an address greater than or equal to the boundary is denied, unless the boundary is in the cleared state.
- R6: A protect clear (protect-select high, opcode 11, address all ones) sets the boundary to all ones and marks it cleared. Every word is then writable and write-all is allowed.
- R7: A protect write (protect-select high, opcode 01) is granted only when the boundary is cleared. It stores the address and ends the cleared state. An explicit write of all ones protects the last word and blocks write-all.
- R8: Write-all (protect-select low, opcode 00, top two address bits 01) is granted only when write is enabled, program-enable is high and the boundary is cleared.
- R9: The lock instruction (protect-select high, opcode 00, address all zeros) sets a permanent flag. Once the flag is set, every protect clear, protect write and lock is denied.
- R10: Memory write, write-all, enable and every protect update need program-enable high. Without it the write-class instructions are denied and enable has no effect.
- R11: The answer appears in the cycle after `instr_valid_i`. Each memory write, write-all, protect clear, protect write and lock gets exactly one pulse, either on the grant output for its kind or on `deny_o`. No pulse appears otherwise.
- R12: Reset leaves the boundary at all ones in the cleared state, and leaves the block unlocked and unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | One-cycle pulse: a decoded instruction is present |
| op_i | input | 2 | Instruction opcode |
| addr_i | input | AW | Address field of the instruction |
| psel_i | input | 1 | Sampled protect-select pin |
| pen_i | input | 1 | Sampled program-enable pin |
| mem_wr_ok_o | output | 1 | Memory word write granted |
| wrall_ok_o | output | 1 | Write-all granted |
| prot_ok_o | output | 1 | Protect clear, protect write or lock granted |
| deny_o | output | 1 | Write-class instruction refused |
| prot_rd_valid_o | output | 1 | Protect read-back valid |
| prot_rd_data_o | output | AW+1 | Dummy zero bit followed by the boundary |

## Verification
The in-line assertions are checked on every cycle. They cover these properties:
- At most one answer pulse per cycle.
- The lock flag never falls once set.
- The boundary never moves unless the block is armed.
- Arming is never held without write enable.
- Write-all and memory-write grants follow the state of the previous cycle.

Some behaviours can only be shown by the bench scenarios, with its per-cycle reference model:
- Arming is cancelled by an intervening read.
- The cleared boundary and the explicitly written all-ones boundary behave differently.
- The boundary comparison holds at the exact address and the addresses next to it.
- A prior clear is required before a protect write.

// File: rtl/prot_auth_pkg.sv
package prot_auth_pkg;
  typedef enum logic [3:0] {
    C_NONE, C_READ, C_WEN, C_WDS, C_WRITE, C_WRALL,
    C_PRREAD, C_ARM, C_PRCLR, C_PRWR, C_LOCK
  } cmd_e;

  typedef struct packed {
    logic mem_wr;
    logic wrall;
    logic prot;
    logic deny;
    logic rd;
  } verdict_t;
endpackage

// File: rtl/prot_auth_decode.sv
module prot_auth_decode
  import prot_auth_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic          psel_i,
  output cmd_e          cmd_o
);
  logic [1:0] top2;
  assign top2 = addr_i[AW-1 -: 2];

  always_comb begin
    cmd_o = C_NONE;
    if (!psel_i) begin
      unique case (op_i)
        2'b10: cmd_o = C_READ;
        2'b01: cmd_o = C_WRITE;
        2'b00: begin
          if (top2 == 2'b11)      cmd_o = C_WEN;
          else if (top2 == 2'b01) cmd_o = C_WRALL;
          else if (top2 == 2'b00) cmd_o = C_WDS;
        end
        default: cmd_o = C_NONE;
      endcase
    end else begin
      unique case (op_i)
        2'b10: cmd_o = C_PRREAD;
        2'b01: cmd_o = C_PRWR;
        2'b11: if (&addr_i) cmd_o = C_PRCLR;
        2'b00: begin
          if (top2 == 2'b11)    cmd_o = C_ARM;
          else if (addr_i == '0) cmd_o = C_LOCK;
        end
        default: cmd_o = C_NONE;
      endcase
    end
  end
endmodule

// File: rtl/prot_auth_judge.sv
module prot_auth_judge
  import prot_auth_pkg::*;
#(
  parameter int AW = 6
) (
  input  cmd_e          cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          pen_i,
  input  logic          wen_i,
  input  logic          armed_i,
  input  logic [AW-1:0] bound_i,
  input  logic          cleared_i,
  input  logic          locked_i,
  output verdict_t      v_o,
  output logic          set_wen_o,
  output logic          clr_wen_o,
  output logic          arm_o,
  output logic          do_clr_o,
  output logic          do_pwr_o,
  output logic          do_lock_o
);
  logic upd_ok;
  assign upd_ok = armed_i && pen_i && !locked_i;

  always_comb begin
    v_o       = '0;
    set_wen_o = 1'b0;
    clr_wen_o = 1'b0;
    arm_o     = 1'b0;
    do_clr_o  = 1'b0;
    do_pwr_o  = 1'b0;
    do_lock_o = 1'b0;
    unique case (cmd_i)
      C_WEN:    set_wen_o = pen_i;
      C_WDS:    clr_wen_o = 1'b1;
      C_WRITE: begin
        if (wen_i && pen_i && (cleared_i || addr_i < bound_i)) v_o.mem_wr = 1'b1;
        else v_o.deny = 1'b1;
      end
      C_WRALL: begin
        if (wen_i && pen_i && cleared_i) v_o.wrall = 1'b1;
        else v_o.deny = 1'b1;
      end
      C_PRREAD: v_o.rd = 1'b1;
      C_ARM:    arm_o = wen_i && pen_i;
      C_PRCLR: begin
        do_clr_o = upd_ok;
        v_o.prot = upd_ok;
        v_o.deny = !upd_ok;
      end
      C_PRWR: begin
        do_pwr_o = upd_ok && cleared_i;
        v_o.prot = upd_ok && cleared_i;
        v_o.deny = !(upd_ok && cleared_i);
      end
      C_LOCK: begin
        do_lock_o = upd_ok;
        v_o.prot  = upd_ok;
        v_o.deny  = !upd_ok;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/prot_auth_state.sv
module prot_auth_state #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          set_wen_i,
  input  logic          clr_wen_i,
  input  logic          arm_i,
  input  logic          do_clr_i,
  input  logic          do_pwr_i,
  input  logic          do_lock_i,
  output logic          wen_o,
  output logic          armed_o,
  output logic [AW-1:0] bound_o,
  output logic          cleared_o,
  output logic          locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_o     <= 1'b0;
      armed_o   <= 1'b0;
      bound_o   <= '1;
      cleared_o <= 1'b1;
      locked_o  <= 1'b0;
    end else if (valid_i) begin
      armed_o <= arm_i;  // any other instruction drops arming
      if (set_wen_i) wen_o <= 1'b1;
      if (clr_wen_i) wen_o <= 1'b0;
      if (do_clr_i) begin
        bound_o   <= '1;
        cleared_o <= 1'b1;
      end
      if (do_pwr_i) begin
        bound_o   <= addr_i;
        cleared_o <= 1'b0;
      end
      if (do_lock_i) locked_o <= 1'b1;
    end
  end
endmodule

// File: rtl/prot_auth_ctrl.sv
module prot_auth_ctrl
  import prot_auth_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_valid_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic          psel_i,
  input  logic          pen_i,
  output logic          mem_wr_ok_o,
  output logic          wrall_ok_o,
  output logic          prot_ok_o,
  output logic          deny_o,
  output logic          prot_rd_valid_o,
  output logic [AW:0]   prot_rd_data_o
);
  cmd_e          cmd;
  verdict_t      v, v_q;
  logic          set_wen, clr_wen, arm, do_clr, do_pwr, do_lock;
  logic          wen_q, armed_q, cleared_q, locked_q;
  logic [AW-1:0] bound_q;

  prot_auth_decode #(.AW(AW)) u_dec (
    .op_i(op_i), .addr_i(addr_i), .psel_i(psel_i), .cmd_o(cmd)
  );

  prot_auth_judge #(.AW(AW)) u_judge (
    .cmd_i(cmd), .addr_i(addr_i), .pen_i(pen_i),
    .wen_i(wen_q), .armed_i(armed_q), .bound_i(bound_q),
    .cleared_i(cleared_q), .locked_i(locked_q),
    .v_o(v), .set_wen_o(set_wen), .clr_wen_o(clr_wen), .arm_o(arm),
    .do_clr_o(do_clr), .do_pwr_o(do_pwr), .do_lock_o(do_lock)
  );

  prot_auth_state #(.AW(AW)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(instr_valid_i), .addr_i(addr_i),
    .set_wen_i(set_wen), .clr_wen_i(clr_wen), .arm_i(arm),
    .do_clr_i(do_clr), .do_pwr_i(do_pwr), .do_lock_i(do_lock),
    .wen_o(wen_q), .armed_o(armed_q), .bound_o(bound_q),
    .cleared_o(cleared_q), .locked_o(locked_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q            <= '0;
      prot_rd_data_o <= '0;
    end else begin
      v_q <= instr_valid_i ? v : '0;
      if (instr_valid_i && v.rd) prot_rd_data_o <= {1'b0, bound_q};
    end
  end

  assign mem_wr_ok_o     = v_q.mem_wr;
  assign wrall_ok_o      = v_q.wrall;
  assign prot_ok_o       = v_q.prot;
  assign deny_o          = v_q.deny;
  assign prot_rd_valid_o = v_q.rd;

  AST_ONE_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({mem_wr_ok_o, wrall_ok_o, prot_ok_o, deny_o, prot_rd_valid_o}) <= 1); // R11
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q); // R9
  AST_BOUND_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(bound_q)); // R4
  AST_ARM_NEEDS_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> wen_q); // R3
  AST_WRALL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !cleared_q |=> !wrall_ok_o); // R8
  AST_WRITE_NEEDS_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !wen_q |=> !mem_wr_ok_o && !wrall_ok_o); // R1
  AST_LOCKED_NO_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && locked_q |=> !prot_ok_o); // R9
  AST_RD_DUMMY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_rd_valid_o |-> !prot_rd_data_o[AW]); // R2
endmodule

// File: tb/prot_auth_ctrl_test.sv
`timescale 1ns/1ps
module prot_auth_ctrl_test;
  localparam int AW  = 6;
  localparam int TOP = (1 << AW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, ps = 1'b0, pe = 1'b0;
  logic [1:0] op = '0;
  logic [AW-1:0] ad = '0;
  logic mem_ok, wall_ok, prot_ok, deny, rd_v;
  logic [AW:0] rd_d;

  always #2 clk = ~clk;

  prot_auth_ctrl #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(vld), .op_i(op), .addr_i(ad),
    .psel_i(ps), .pen_i(pe), .mem_wr_ok_o(mem_ok), .wrall_ok_o(wall_ok),
    .prot_ok_o(prot_ok), .deny_o(deny), .prot_rd_valid_o(rd_v), .prot_rd_data_o(rd_d)
  );

  // reference model state
  int  m_wen = 0, m_armed = 0, m_bound = TOP, m_clr = 1, m_lock = 0;
  bit  e_mem, e_wall, e_prot, e_deny, e_rd;
  int  e_data;
  string tag = "R12";
  int  n_cmp = 0, n_bad = 0;

  task automatic cmp(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cmp("mem_wr_ok", mem_ok, e_mem);
    cmp("wrall_ok", wall_ok, e_wall);
    cmp("prot_ok", prot_ok, e_prot);
    cmp("deny", deny, e_deny);
    cmp("rd_valid", rd_v, e_rd);
    if (e_rd) cmp("rd_data", rd_d, e_data);
  end

  task automatic issue(input logic [1:0] o, input int a, input bit s, input bit p,
                       input string t);
    int nxt_arm;
    int t2;
    @(negedge clk);
    vld = 1'b1; op = o; ad = a[AW-1:0]; ps = s; pe = p; tag = t;
    {e_mem, e_wall, e_prot, e_deny, e_rd} = '0;
    nxt_arm = 0;
    t2 = a >> (AW - 2);
    if (!s) begin
      if (o == 2'b01) begin
        if (m_wen && p && (m_clr || a < m_bound)) e_mem = 1; else e_deny = 1;
      end else if (o == 2'b00) begin
        if (t2 == 3 && p) m_wen = 1;
        else if (t2 == 1) begin
          if (m_wen && p && m_clr) e_wall = 1; else e_deny = 1;
        end else if (t2 == 0) m_wen = 0;
      end
    end else begin
      if (o == 2'b10) begin
        e_rd = 1; e_data = m_bound;
      end else if (o == 2'b00 && t2 == 3) begin
        nxt_arm = m_wen && p;
      end else if (o == 2'b00 && a == 0) begin
        if (m_armed && p && !m_lock) begin e_prot = 1; m_lock = 1; end else e_deny = 1;
      end else if (o == 2'b11 && a == TOP) begin
        if (m_armed && p && !m_lock) begin e_prot = 1; m_bound = TOP; m_clr = 1; end
        else e_deny = 1;
      end else if (o == 2'b01) begin
        if (m_armed && p && !m_lock && m_clr) begin e_prot = 1; m_bound = a; m_clr = 0; end
        else e_deny = 1;
      end
    end
    m_armed = nxt_arm;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0;
      {e_mem, e_wall, e_prot, e_deny, e_rd} = '0;
    end
  endtask

  // opcode helpers (top two address bits select sub-commands of opcode 00)
  localparam int A_EN = 3 << (AW - 2), A_WALL = 1 << (AW - 2);

  initial begin
    {e_mem, e_wall, e_prot, e_deny, e_rd} = '0;
    e_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R12: reset boundary readable as all ones, dummy bit zero
    issue(2'b10, 0, 1, 0, "R12");
    // R1: no write before enable
    issue(2'b01, 3, 0, 1, "R1");
    // R10: enable without program-enable has no effect
    issue(2'b00, A_EN, 0, 0, "R10");
    issue(2'b01, 3, 0, 1, "R10");
    issue(2'b00, A_EN, 0, 1, "R1");
    issue(2'b01, 3, 0, 1, "R1");
    issue(2'b01, 3, 0, 0, "R10");
    issue(2'b00, A_WALL, 0, 0, "R10");
    // R2: memory read silent, protect read answers
    issue(2'b10, 5, 0, 0, "R2");
    issue(2'b10, 5, 1, 0, "R2");
    // R3: arming without program-enable rejected
    issue(2'b00, A_EN, 1, 0, "R3");
    issue(2'b11, TOP, 1, 1, "R3");
    // R4: arming cancelled by an intervening read
    issue(2'b00, A_EN, 1, 1, "R4");
    issue(2'b10, 0, 1, 0, "R4");
    issue(2'b11, TOP, 1, 1, "R4");
    // R6: clear then last word and write-all allowed
    issue(2'b00, A_EN, 1, 1, "R6");
    issue(2'b11, TOP, 1, 1, "R6");
    issue(2'b01, TOP, 0, 1, "R6");
    issue(2'b00, A_WALL, 0, 1, "R8");
    // R7: protect write of boundary 10
    issue(2'b00, A_EN, 1, 1, "R7");
    issue(2'b01, 10, 1, 1, "R7");
    issue(2'b10, 0, 1, 0, "R2");
    // R5: boundary comparison
    issue(2'b01, 9, 0, 1, "R5");
    issue(2'b01, 10, 0, 1, "R5");
    issue(2'b01, 11, 0, 1, "R5");
    issue(2'b00, A_WALL, 0, 1, "R8");
    // R7: protect write without prior clear denied
    issue(2'b00, A_EN, 1, 1, "R7");
    issue(2'b01, 20, 1, 1, "R7");
    issue(2'b10, 0, 1, 0, "R7");
    // R7: explicit all ones protects last word and blocks write-all
    issue(2'b00, A_EN, 1, 1, "R6");
    issue(2'b11, TOP, 1, 1, "R6");
    issue(2'b00, A_EN, 1, 1, "R7");
    issue(2'b01, TOP, 1, 1, "R7");
    issue(2'b01, TOP, 0, 1, "R7");
    issue(2'b01, TOP - 1, 0, 1, "R7");
    issue(2'b00, A_WALL, 0, 1, "R7");
    // R1: disable revokes, arming then refused
    issue(2'b00, 0, 0, 1, "R1");
    issue(2'b01, 1, 0, 1, "R1");
    issue(2'b00, A_EN, 1, 1, "R3");
    issue(2'b11, TOP, 1, 1, "R3");
    issue(2'b00, A_EN, 0, 1, "R1");
    // R9: lock, then everything on the boundary refused
    issue(2'b00, A_EN, 1, 1, "R9");
    issue(2'b00, 0, 1, 1, "R9");
    issue(2'b00, A_EN, 1, 1, "R9");
    issue(2'b11, TOP, 1, 1, "R9");
    issue(2'b00, A_EN, 1, 1, "R9");
    issue(2'b00, 0, 1, 1, "R9");
    issue(2'b10, 0, 1, 0, "R9");
    // R11: write still works below boundary after lock
    issue(2'b01, 4, 0, 1, "R11");
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL R11 watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule